// File: doc/BRIEF.md
# Eight-Channel Trigger-Selectable Interrupt Input Bank

This block watches eight external input lines and turns selected activity on them into a single interrupt request. Each line first passes through a two-stage synchronizer. A per-channel detector then compares successive synchronized samples and decides whether the channel has been triggered. Three configuration bits pick one of five trigger types for each channel: rising edge, falling edge, any edge, high level or low level.

Every channel has a small status state machine with two states, `CH_QUIET` and `CH_PENDING`. The transition `arm` (QUIET to PENDING) fires on a trigger. The transition `release` (PENDING to QUIET) fires on a write-one clear in a cycle with no trigger. In every other case the state is held: `hold_quiet` and `hold_pending`. Status bits are ANDed with per-channel enables, and the interrupt output is the OR of the result.

Software reaches the block through a 32-bit register bus. Writes take effect on a clock edge, and reads are combinational on the word address. Bit n of every register belongs to channel n, and bits 31:8 always read as zero.

Top module: `eint_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. Configuration resets to falling-edge detection with all enables off.
- R2: The input-data register (byte offset 0x1C) returns each input after two clock edges of synchronization. A change driven before edge k is visible after edge k+1.
- R3: With level-select 0, any-edge 0 and polarity 1, a rising input sets that channel's status on the third edge after the change. A falling input leaves the status unchanged.
- R4: With level-select 0, any-edge 0 and polarity 0, a falling input sets status and a rising input does not.
- R5: With level-select 0 and any-edge 1, both rising and falling changes set status, for either polarity value.
- R6: With level-select 1, a channel whose synchronized input equals its polarity bit sets status. A channel whose input differs does not.
- R7: Status stays set until a 1 is written to its bit in the clear register (offset 0x0C). Writing 0 bits leaves status unchanged, and the clear register reads 0.
- R8: In level mode, a clear does not drop status while the level is still active. Once the level is inactive, a clear drops it.
- R9: When a clear and a trigger on the same channel fall in the same cycle, the status ends set.
- R10: The masked register (0x08) equals raw status (0x04) AND enable (0x00). `irq_o` is the OR of the masked bits.
- R11: The enable (0x00), level-select (0x10), any-edge (0x14) and polarity (0x18) registers read back the low 8 bits last written, with bits 31:8 at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous input lines, one per channel |
| reg_addr | input | 5 | Byte address of the register; bits 1:0 are ignored |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The collision of interest is a software clear arriving in the same cycle that a channel's detector fires. This would lose an event if the clear had priority. The bench times a rising input so that its third synchronizing edge coincides with the edge that samples a clear write for that channel. It then expects the raw status bit to remain 1, and a later plain clear must still drop it. The same priority is exercised in level mode, where a clear against an active level must not be visible at all.

// File: rtl/eint_pkg.sv
package eint_pkg;
    // Word index of each register (byte offset >> 2)
    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_RAW    = 3'd1,
        RG_MASKED = 3'd2,
        RG_CLEAR  = 3'd3,
        RG_LEVEL  = 3'd4,
        RG_ANY    = 3'd5,
        RG_POL    = 3'd6,
        RG_DATA   = 3'd7
    } reg_sel_e;

    typedef enum logic {
        CH_QUIET   = 1'b0,
        CH_PENDING = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic lvl;   // 1: level detection, 0: edge detection
        logic any;   // edge mode only: trigger on both edges
        logic pol;   // 1: rising / high, 0: falling / low
    } trig_cfg_t;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/eint_chan.sv
module eint_chan
    import eint_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cur_i,
    input  trig_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      stat_o
);
    ch_state_e state_q, state_d;
    logic      prev_q;
    logic      rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur_i;
    end

    // Trigger decode: level wins over edge; any-edge overrides polarity
    always_comb begin
        rise = cur_i & ~prev_q;
        fall = ~cur_i & prev_q;
        if (cfg_i.lvl)      hit = (cur_i == cfg_i.pol);
        else if (cfg_i.any) hit = rise | fall;
        else if (cfg_i.pol) hit = rise;
        else                hit = fall;
    end

    // Next-state logic: arm / release / hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_QUIET:   state_d = hit ? CH_PENDING : CH_QUIET;
            CH_PENDING: state_d = (clr_i && !hit) ? CH_QUIET : CH_PENDING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        stat_o = (state_q == CH_PENDING);
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && clr_i && !hit) |=> !stat_o); // R7

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && hit) |=> stat_o); // R9

    AST_LEVEL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.lvl && (cur_i == cfg_i.pol)) |=> stat_o); // R6
endmodule

// File: rtl/eint_bank.sv
module eint_bank
    import eint_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - NUM_CH;

    reg_sel_e          sel;
    logic [NUM_CH-1:0] wr_bits;
    logic [NUM_CH-1:0] en_q, lvl_q, any_q, pol_q;
    logic [NUM_CH-1:0] sync_in, raw, masked, clr_vec;
    logic [NUM_CH-1:0] rd_bits;
    logic              unused_bits;

    assign sel         = reg_sel_e'(reg_addr[ADDR_W-1:2]);
    assign wr_bits     = reg_wdata[NUM_CH-1:0];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:NUM_CH]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            lvl_q <= '0;
            any_q <= '0;
            pol_q <= '0;
        end else if (reg_we) begin
            case (sel)
                RG_ENABLE: en_q  <= wr_bits;
                RG_LEVEL:  lvl_q <= wr_bits;
                RG_ANY:    any_q <= wr_bits;
                RG_POL:    pol_q <= wr_bits;
                default:   ;
            endcase
        end
    end

    assign clr_vec = (reg_we && sel == RG_CLEAR) ? wr_bits : '0;

    eint_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_in)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        trig_cfg_t cfg;
        assign cfg = '{lvl: lvl_q[g], any: any_q[g], pol: pol_q[g]};

        eint_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur_i  (sync_in[g]),
            .cfg_i  (cfg),
            .clr_i  (clr_vec[g]),
            .stat_o (raw[g])
        );
    end

    assign masked = raw & en_q;
    assign irq_o  = |masked;

    always_comb begin
        unique case (sel)
            RG_ENABLE: rd_bits = en_q;
            RG_RAW:    rd_bits = raw;
            RG_MASKED: rd_bits = masked;
            RG_CLEAR:  rd_bits = '0;
            RG_LEVEL:  rd_bits = lvl_q;
            RG_ANY:    rd_bits = any_q;
            RG_POL:    rd_bits = pol_q;
            RG_DATA:   rd_bits = sync_in;
        endcase
        reg_rdata = {{PAD_W{1'b0}}, rd_bits};
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o); // R10

    AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> !irq_o); // R10
endmodule

// File: tb/eint_bank_bench.sv
`timescale 1ns/1ps
module eint_bank_bench;
    localparam logic [4:0] A_EN = 5'h00, A_RAW = 5'h04, A_MSK = 5'h08, A_CLR = 5'h0C;
    localparam logic [4:0] A_LVL = 5'h10, A_ANY = 5'h14, A_POL = 5'h18, A_DAT = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     mon_ev;

    always #5 clk = ~clk;

    eint_bank u_eint_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (reg_rdata !== it.data || irq_o !== it.irq) begin
                    n_fail++;
                    $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, it.addr, reg_rdata, irq_o, it.data, it.irq);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic pins(input logic [7:0] v);
        @(negedge clk);
        pin_i = v;
    endtask

    // Driver: sets the address and pushes the expected result
    task automatic chk(input logic [4:0] a, input logic [31:0] d, input logic irq, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.addr = a; it.data = d; it.irq = irq; it.tag = tag;
        sb_q.push_back(it);
        #1 -> mon_ev;
        #1;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            report();
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;

        // R1: reset state of every register
        for (int i = 0; i < 8; i++) chk(5'(i * 4), 32'h0, 1'b0, "R1 reset value");

        // ch0 rise, ch1 fall, ch2 any(pol0), ch3 high, ch4 low, ch5 any(pol1), ch6/7 rise
        wr(A_POL, 32'hFFFF_FFE9);
        wr(A_ANY, 32'h0000_0024);
        wr(A_LVL, 32'h0000_0018);
        chk(A_POL, 32'h0000_00E9, 1'b0, "R11 polarity readback");
        chk(A_ANY, 32'h0000_0024, 1'b0, "R11 any-edge readback");
        chk(A_LVL, 32'h0000_0018, 1'b0, "R11 level readback");
        tick(2);
        chk(A_RAW, 32'h10, 1'b0, "R6 low level sets ch4");
        chk(A_MSK, 32'h00, 1'b0, "R10 masked with enable off");
        wr(A_CLR, 32'hFF);
        chk(A_RAW, 32'h10, 1'b0, "R8 clear ignored while level active");
        chk(A_CLR, 32'h00, 1'b0, "R7 clear reads zero");

        // R2 and R3: synchronizer latency and rising edge
        pins(8'h01);
        chk(A_DAT, 32'h00, 1'b0, "R2 data before second edge");
        chk(A_DAT, 32'h01, 1'b0, "R2 data after second edge");
        chk(A_RAW, 32'h11, 1'b0, "R3 rising edge sets ch0");
        wr(A_CLR, 32'h01);
        chk(A_RAW, 32'h10, 1'b0, "R7 clear drops ch0");
        pins(8'h00);
        tick(3);
        chk(A_RAW, 32'h10, 1'b0, "R3 falling edge ignored on ch0");

        // R4: falling-edge channel
        pins(8'h02);
        tick(3);
        chk(A_RAW, 32'h10, 1'b0, "R4 rising edge ignored on ch1");
        pins(8'h00);
        tick(3);
        chk(A_RAW, 32'h12, 1'b0, "R4 falling edge sets ch1");

        // R5: any-edge channels
        pins(8'h04);
        tick(3);
        chk(A_RAW, 32'h16, 1'b0, "R5 ch2 rising with polarity 0");
        pins(8'h24);
        tick(3);
        chk(A_RAW, 32'h36, 1'b0, "R5 ch5 rising with polarity 1");
        wr(A_CLR, 32'h24);
        chk(A_RAW, 32'h12, 1'b0, "R7 clear ch2 and ch5");
        pins(8'h00);
        tick(3);
        chk(A_RAW, 32'h36, 1'b0, "R5 falling edges set ch2 and ch5");
        wr(A_CLR, 32'h00);
        chk(A_RAW, 32'h36, 1'b0, "R7 zero bits leave status");

        // R6 and R8: high-level channel
        pins(8'h08);
        tick(3);
        chk(A_RAW, 32'h3E, 1'b0, "R6 high level sets ch3");
        wr(A_CLR, 32'h08);
        chk(A_RAW, 32'h3E, 1'b0, "R8 clear ignored while high");
        pins(8'h10);
        tick(3);
        chk(A_RAW, 32'h3E, 1'b0, "R8 status held after level ends");
        wr(A_CLR, 32'h18);
        chk(A_RAW, 32'h26, 1'b0, "R8 clear works once inactive");
        chk(A_DAT, 32'h10, 1'b0, "R2 data follows input");

        // R10 and R11: enables, masked status and interrupt
        wr(A_EN, 32'h06);
        chk(A_MSK, 32'h06, 1'b1, "R10 masked equals raw and enable");
        wr(A_EN, 32'h80);
        chk(A_MSK, 32'h00, 1'b0, "R10 no masked bits no interrupt");
        chk(A_EN, 32'h80, 1'b0, "R11 enable readback");
        wr(A_EN, 32'hFFFF_FFFF);
        chk(A_EN, 32'hFF, 1'b1, "R11 enable upper bits zero");
        chk(A_MSK, 32'h26, 1'b1, "R10 full enable");

        // R9: clear sampled on the same edge that arms ch6
        pins(8'h50);
        tick(1);
        wr(A_CLR, 32'h40);
        chk(A_RAW, 32'h66, 1'b1, "R9 set wins over clear");
        wr(A_CLR, 32'h40);
        chk(A_RAW, 32'h26, 1'b1, "R9 later clear drops ch6");

        done = 1'b1;
        report();
    end
endmodule